// File: doc/BRIEF.md
# Hardware Performance Counter Bank

This block holds the machine-level event counters of a RISC-V style core. It has a 64-bit cycle counter, a 64-bit retired-instruction counter and six generic 64-bit counters numbered 3 to 8. Each generic counter has its own select register. The select value names one of 22 single-cycle event strobes that the rest of the core drives into `evt_strobe`. Software can freeze any counter with an inhibit register.

All registers are reached through one CSR-style request port. The request carries an address, a write flag, write data and the privilege level of the requester. Machine mode reads and writes the counters directly. Supervisor and user code see read-only aliases of the counters. A supervisor read needs the counter's bit in a machine-level enable mask. A user read also needs the counter's bit in a supervisor-level enable mask. The datapath is 32 bits wide by default, so every 64-bit counter is accessed as a low half and a high half. Each request gets one registered response in the following cycle, which carries the read data and an illegal-access flag.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every register reads zero: the counters, the select registers, the inhibit register and both enable masks. `rsp_valid` and `rsp_illegal` are low.
- R2: Counter slot 0 (cycle) increments on every clock. Slot 2 (retired instructions) increments on every clock in which `retire` is high.
- R3: While bit i of the inhibit register (address 0x320) is set, counter slot i does not change except by a software write. Slot 0 is cycle, slot 2 is retired instructions and slots 3 to 8 are the generic counters.
- R4: In 32-bit mode, the machine low half of slot i is at 0xB00+i and the high half is at 0xB80+i. Writing one half leaves the other half unchanged. An increment that carries out of the low half adds one to the high half on the same edge.
- R5: Select register 0x320+i (i = 3..8) holding value k in 1..22 makes counter i count the clocks in which bit k-1 of `evt_strobe` is high. All other strobe bits have no effect on that counter.
- R6: A select value of 0 counts nothing. A write of a value above 22 to a select register stores 0.
- R7: A software write to a counter half wins over an increment on the same edge. A read in the next cycle returns exactly the written value.
- R8: Bit 1 of the inhibit register, and every bit above 8, is held at zero and reads as zero.
- R9: Privilege is encoded 3 = machine, 1 = supervisor, 0 = user. A request whose privilege is below address bits [9:8] is illegal. A supervisor read of a view at 0xC00+i or 0xC80+i needs bit i of the machine enable mask at 0x306.
- R10: A user read of a view needs bit i of the machine mask and bit i of the supervisor mask at 0x106. The supervisor mask is accessible from supervisor and machine mode only.
- R11: A request is illegal if it writes to a read-only view (address bits [11:10] = 3), is a gated read that is refused, or targets an unmapped address. An illegal request changes no state, and its response has `rsp_illegal` high and `rsp_data` zero.
- R12: A read of view 0xC00+i or 0xC80+i returns the same value as machine address 0xB00+i or 0xB80+i.
- R13: Every request gets a response with `rsp_valid` high for exactly one cycle, one clock after the request. The response data of a write is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Register access request this cycle |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_priv | input | 2 | Privilege of the requester (3 M, 1 S, 0 U) |
| retire | input | 1 | One instruction retired this cycle |
| evt_strobe | input | NUM_EVT | Event pulses; bit k-1 carries event k |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | XLEN | Read data, zero for writes and illegal requests |
| rsp_illegal | output | 1 | Request was refused |

## Verification
The bench builds the block with its defaults: XLEN = 32, 64-bit counters, six generic counters and 22 events. A 32-bit datapath is needed to reach the split-half behaviour at all, since only there do the high-half addresses exist. In that mode the bench can preload the cycle counter just below a 32-bit boundary and run it across the boundary, which shows the carry into the high half. With the full event list, the bench can select the first-indexed and last-indexed strobes, as well as out-of-range select values, in the same run.

// File: rtl/perf_pkg.sv
package perf_pkg;

  // Requester privilege, numerically ordered so that a compare works.
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  // Register class selected by an address.
  typedef enum logic [2:0] {
    REG_NONE,
    REG_CNT,
    REG_SEL,
    REG_INH,
    REG_MEN,
    REG_SEN
  } reg_kind_e;

  localparam logic [11:0] ADDR_INH = 12'h320;
  localparam logic [11:0] ADDR_MEN = 12'h306;
  localparam logic [11:0] ADDR_SEN = 12'h106;

  // 32-entry address pages, addr[11:5]
  localparam logic [6:0] PG_SEL      = 7'h19;  // 0x320..0x33F
  localparam logic [6:0] PG_CNT_M_LO = 7'h58;  // 0xB00..0xB1F
  localparam logic [6:0] PG_CNT_M_HI = 7'h5C;  // 0xB80..0xB9F
  localparam logic [6:0] PG_CNT_V_LO = 7'h60;  // 0xC00..0xC1F
  localparam logic [6:0] PG_CNT_V_HI = 7'h64;  // 0xC80..0xC9F

endpackage

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
  import perf_pkg::*;
#(
  parameter int NCNT   = 9,
  parameter bit HAS_HI = 1'b1
) (
  input  logic [11:0] addr,
  output reg_kind_e   kind,
  output logic [4:0]  idx,
  output logic        hi,
  output logic        ro
);
  localparam logic [4:0] LIMIT = 5'(NCNT);

  logic [6:0] page;
  logic       slot_ok;
  logic       is_lo;
  logic       is_hi;

  always_comb begin
    page    = addr[11:5];
    idx     = addr[4:0];
    is_lo   = (page == PG_CNT_M_LO) || (page == PG_CNT_V_LO);
    is_hi   = HAS_HI && ((page == PG_CNT_M_HI) || (page == PG_CNT_V_HI));
    slot_ok = (idx != 5'd1) && (idx < LIMIT);
    hi      = is_hi;
    ro      = (page == PG_CNT_V_LO) || (page == PG_CNT_V_HI);
    kind    = REG_NONE;
    if (addr == ADDR_INH) begin
      kind = REG_INH;
    end else if (addr == ADDR_MEN) begin
      kind = REG_MEN;
    end else if (addr == ADDR_SEN) begin
      kind = REG_SEN;
    end else if (page == PG_SEL) begin
      if (idx >= 5'd3 && idx < LIMIT) kind = REG_SEL;
    end else if ((is_lo || is_hi) && slot_ok) begin
      kind = REG_CNT;
    end
  end

endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
  parameter int NUM_EVT = 22,
  parameter int SEL_W   = 5
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit
);
  // Value k (1..NUM_EVT) picks strobe k-1; anything else picks nothing.
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel == SEL_W'(k + 1)) hit = evt[k];
    end
  end

endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 64,
  parameter int XLEN  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] value
);
  generate
    if (XLEN < CNT_W) begin : g_split
      always_ff @(posedge clk) begin
        if (rst) begin
          value <= '0;
        end else if (wr_lo) begin
          value <= {value[CNT_W-1:XLEN], wdata};
        end else if (wr_hi) begin
          value <= {wdata[CNT_W-XLEN-1:0], value[XLEN-1:0]};
        end else if (inc) begin
          value <= value + 1'b1;
        end
      end
    end else begin : g_whole
      always_ff @(posedge clk) begin
        if (rst) begin
          value <= '0;
        end else if (wr_lo | wr_hi) begin
          value <= CNT_W'(wdata);
        end else if (inc) begin
          value <= value + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CNT_W   = 64,
  parameter int NUM_GEN = 6,
  parameter int NUM_EVT = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_req,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic [1:0]         csr_priv,
  input  logic               retire,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               rsp_valid,
  output logic [XLEN-1:0]    rsp_data,
  output logic               rsp_illegal
);
  localparam int              NCNT     = NUM_GEN + 3;
  localparam int              SEL_W    = $clog2(NUM_EVT + 1);
  localparam bit              HAS_HI   = (XLEN < CNT_W);
  localparam logic [NCNT-1:0] INH_KEEP = ~(NCNT'(2));

  reg_kind_e  kind;
  logic [4:0] idx;
  logic       hi;
  logic       ro;

  perf_csr_decode #(.NCNT(NCNT), .HAS_HI(HAS_HI)) u_dec (
    .addr (csr_addr),
    .kind (kind),
    .idx  (idx),
    .hi   (hi),
    .ro   (ro)
  );

  logic [NCNT-1:0]  inh_q;
  logic [NCNT-1:0]  men_q;
  logic [NCNT-1:0]  sen_q;
  logic [SEL_W-1:0] sel_q [NCNT];
  logic [CNT_W-1:0] cnt   [NCNT];
  logic [NCNT-1:0]  cnt_wlo;
  logic [NCNT-1:0]  cnt_whi;
  logic [NCNT-1:0]  cnt_inc;

  // Access legality
  logic [31:0] men_pad;
  logic [31:0] sen_pad;
  logic        priv_ok;
  logic        view_ok;
  logic        legal;
  logic        wr_fire;

  assign men_pad = 32'(men_q);
  assign sen_pad = 32'(sen_q);

  always_comb begin
    priv_ok = (csr_priv >= csr_addr[9:8]);
    view_ok = 1'b1;
    if (ro && kind == REG_CNT && csr_priv != PRIV_M) begin
      view_ok = men_pad[idx] & ((csr_priv == PRIV_S) | sen_pad[idx]);
    end
    legal = (kind != REG_NONE) && priv_ok && view_ok && !(csr_we && ro);
  end

  assign wr_fire = csr_req & csr_we & legal;

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      cnt_wlo[i] = wr_fire && kind == REG_CNT && !hi && idx == 5'(i);
      cnt_whi[i] = wr_fire && kind == REG_CNT &&  hi && idx == 5'(i);
    end
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q <= '0;
      men_q <= '0;
      sen_q <= '0;
      for (int i = 0; i < NCNT; i++) sel_q[i] <= '0;
    end else if (wr_fire) begin
      case (kind)
        REG_INH: inh_q <= csr_wdata[NCNT-1:0] & INH_KEEP;
        REG_MEN: men_q <= csr_wdata[NCNT-1:0];
        REG_SEN: sen_q <= csr_wdata[NCNT-1:0];
        REG_SEL: begin
          for (int i = 0; i < NCNT; i++) begin
            if (idx == 5'(i)) begin
              sel_q[i] <= (csr_wdata <= XLEN'(NUM_EVT)) ? SEL_W'(csr_wdata) : '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Counter slots: 0 cycle, 1 empty, 2 retired, 3.. generic
  genvar g;
  generate
    for (g = 0; g < NCNT; g++) begin : g_cnt
      if (g == 1) begin : g_gap
        assign cnt[g]     = '0;
        assign cnt_inc[g] = 1'b0;
      end else begin : g_live
        logic src;
        if (g == 0) begin : g_cyc
          assign src = 1'b1;
        end else if (g == 2) begin : g_ret
          assign src = retire;
        end else begin : g_evt
          perf_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
            .sel (sel_q[g]),
            .evt (evt_strobe),
            .hit (src)
          );
        end
        assign cnt_inc[g] = src & ~inh_q[g];
        perf_counter #(.CNT_W(CNT_W), .XLEN(XLEN)) u_cnt (
          .clk   (clk),
          .rst   (rst),
          .inc   (cnt_inc[g]),
          .wr_lo (cnt_wlo[g]),
          .wr_hi (cnt_whi[g]),
          .wdata (csr_wdata),
          .value (cnt[g])
        );
      end
    end
  endgenerate

  // Read mux
  logic [CNT_W-1:0] pick_cnt;
  logic [SEL_W-1:0] pick_sel;
  logic [XLEN-1:0]  rd_val;

  always_comb begin
    pick_cnt = '0;
    pick_sel = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (idx == 5'(i)) begin
        pick_cnt = cnt[i];
        pick_sel = sel_q[i];
      end
    end
    case (kind)
      REG_CNT: rd_val = hi ? XLEN'(pick_cnt >> XLEN) : XLEN'(pick_cnt);
      REG_SEL: rd_val = XLEN'(pick_sel);
      REG_INH: rd_val = XLEN'(inh_q);
      REG_MEN: rd_val = XLEN'(men_q);
      REG_SEN: rd_val = XLEN'(sen_q);
      default: rd_val = '0;
    endcase
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= csr_req;
      rsp_illegal <= csr_req & ~legal;
      rsp_data    <= (csr_req && legal && !csr_we) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64,
  parameter int NCNT  = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_req,
  input logic             csr_we,
  input logic [11:0]      csr_addr,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [1:0]       csr_priv,
  input logic             rsp_valid,
  input logic [XLEN-1:0]  rsp_data,
  input logic             rsp_illegal,
  input logic [NCNT-1:0]  inh,
  input logic [NCNT-1:0]  men,
  input logic [NCNT-1:0]  sen,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] gen_cnt,
  input logic [NCNT-1:0]  wlo,
  input logic [NCNT-1:0]  whi
);

  a_r11_flag_has_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> rsp_valid);

  a_r11_flag_zero_data: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> rsp_data == '0);

  a_r11_view_write_refused: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_we && csr_addr[11:10] == 2'b11) |=> rsp_illegal);

  a_r8_inh_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (csr_req && !csr_we && csr_addr == 12'h320) |=> !rsp_data[1]);

  a_r2_cycle_tick: assert property (@(posedge clk) disable iff (rst)
    (!inh[0] && !wlo[0] && !whi[0]) |=> cycle_cnt == $past(cycle_cnt) + 1'b1);

  a_r3_generic_frozen: assert property (@(posedge clk) disable iff (rst)
    (inh[3] && !wlo[3] && !whi[3]) |=> $stable(gen_cnt));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    wlo[0] |=> cycle_cnt[XLEN-1:0] == $past(csr_wdata));

  a_r10_user_gate: assert property (@(posedge clk) disable iff (rst)
    (csr_req && !csr_we && csr_priv == 2'b00 && csr_addr == 12'hC03 && !(men[3] && sen[3]))
      |=> rsp_illegal);

endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.XLEN(XLEN), .CNT_W(CNT_W), .NCNT(NCNT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_req     (csr_req),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .csr_priv    (csr_priv),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .rsp_illegal (rsp_illegal),
  .inh         (inh_q),
  .men         (men_q),
  .sen         (sen_q),
  .cycle_cnt   (cnt[0]),
  .gen_cnt     (cnt[3]),
  .wlo         (cnt_wlo),
  .whi         (cnt_whi)
);

// File: tb/tb_perf_ctr_bank.sv
module tb_perf_ctr_bank;
  localparam int XLEN    = 32;
  localparam int NUM_EVT = 22;
  localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00;
  localparam logic [NUM_EVT-1:0] ALL_EVT = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic               csr_req = 1'b0;
  logic               csr_we = 1'b0;
  logic [11:0]        csr_addr = '0;
  logic [XLEN-1:0]    csr_wdata = '0;
  logic [1:0]         csr_priv = PM;
  logic               retire = 1'b0;
  logic [NUM_EVT-1:0] evt_strobe = '0;
  logic               rsp_valid;
  logic [XLEN-1:0]    rsp_data;
  logic               rsp_illegal;

  perf_ctr_bank dut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_priv(csr_priv), .retire(retire), .evt_strobe(evt_strobe),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  // Scoreboard
  logic [XLEN-1:0] q_data[$];
  logic            q_ill[$];
  string           q_tag[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic op(input logic we, input logic [11:0] a, input logic [XLEN-1:0] wd,
                    input logic [1:0] p, input logic [XLEN-1:0] ed, input logic ei,
                    input string tag);
    csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd; csr_priv = p;
    q_data.push_back(ed); q_ill.push_back(ei); q_tag.push_back(tag);
    @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] p, input logic [XLEN-1:0] ed,
                    input string tag);
    op(1'b0, a, '0, p, ed, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] wd, input logic [1:0] p,
                    input string tag);
    op(1'b1, a, wd, p, '0, 1'b0, tag);
  endtask

  task automatic refused(input logic we, input logic [11:0] a, input logic [1:0] p,
                         input string tag);
    op(we, a, 32'h55, p, '0, 1'b1, tag);
  endtask

  task automatic strobe(input logic [NUM_EVT-1:0] m, input int n);
    evt_strobe = m;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic retire_for(input int n);
    retire = 1'b1;
    repeat (n) @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) begin
        n_bad++;
        $display("FAIL R13: response data=%h ill=%b, expected no response", rsp_data, rsp_illegal);
      end else begin
        logic [XLEN-1:0] ed;
        logic            ei;
        string           t;
        ed = q_data.pop_front();
        ei = q_ill.pop_front();
        t  = q_tag.pop_front();
        n_cmp++;
        if (rsp_data !== ed || rsp_illegal !== ei) begin
          n_bad++;
          $display("FAIL %s: got data=%h ill=%b, expected data=%h ill=%b",
                   t, rsp_data, rsp_illegal, ed, ei);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: idle outputs valid=%b ill=%b, expected 0 0", rsp_valid, rsp_illegal);
    end

    // R1 reset values
    rd(12'hB02, PM, 32'h0, "R1");
    rd(12'hB03, PM, 32'h0, "R1");
    rd(12'hB88, PM, 32'h0, "R1");
    rd(12'h323, PM, 32'h0, "R1");
    rd(12'h320, PM, 32'h0, "R1");
    rd(12'h306, PM, 32'h0, "R1");
    rd(12'h106, PM, 32'h0, "R1");

    // R8 inhibit reserved bits, freeze everything
    wr(12'h320, 32'hFFFF_FFFF, PM, "R8");
    rd(12'h320, PM, 32'h0000_01FD, "R8");

    // R4 split halves
    wr(12'hB80, 32'h12, PM, "R4");
    wr(12'hB00, 32'hFFFF_FFFE, PM, "R4");
    rd(12'hB00, PM, 32'hFFFF_FFFE, "R4");
    rd(12'hB80, PM, 32'h12, "R4");
    wr(12'hB80, 32'h13, PM, "R4");
    rd(12'hB00, PM, 32'hFFFF_FFFE, "R4");

    // R2/R4 three cycle ticks across the low-half boundary
    wr(12'h320, 32'h1FC, PM, "R2");
    repeat (2) @(negedge clk);
    wr(12'h320, 32'h1FD, PM, "R2");
    rd(12'hB00, PM, 32'h1, "R4");
    rd(12'hB80, PM, 32'h14, "R4");

    // R7 write beats increment while running
    wr(12'h320, 32'h1FC, PM, "R7");
    wr(12'hB00, 32'h100, PM, "R7");
    rd(12'hB00, PM, 32'h100, "R7");
    rd(12'hB80, PM, 32'h14, "R7");
    wr(12'h320, 32'h1FD, PM, "R3");

    // R2/R3 retired-instruction counter
    wr(12'h320, 32'h1F9, PM, "R2");
    retire_for(5);
    rd(12'hB02, PM, 32'h5, "R2");
    wr(12'h320, 32'h1FD, PM, "R3");
    retire_for(3);
    rd(12'hB02, PM, 32'h5, "R3");

    // R5 event selection
    wr(12'h323, 32'd5, PM, "R5");
    wr(12'h324, 32'd22, PM, "R5");
    rd(12'h323, PM, 32'd5, "R5");
    wr(12'h320, 32'h1E5, PM, "R5");
    strobe(NUM_EVT'(1) << 4, 4);
    strobe((NUM_EVT'(1) << 21) | (NUM_EVT'(1) << 3), 2);
    strobe(ALL_EVT & ~((NUM_EVT'(1) << 4) | (NUM_EVT'(1) << 21)), 3);
    rd(12'hB03, PM, 32'h4, "R5");
    rd(12'hB04, PM, 32'h2, "R5");

    // R6 null and out-of-range selection
    wr(12'h325, 32'd23, PM, "R6");
    rd(12'h325, PM, 32'h0, "R6");
    wr(12'h320, 32'h005, PM, "R6");
    strobe(ALL_EVT, 3);
    rd(12'hB05, PM, 32'h0, "R6");
    rd(12'hB06, PM, 32'h0, "R6");
    rd(12'hB03, PM, 32'h7, "R5");
    rd(12'hB04, PM, 32'h5, "R5");

    // R3 generic counters frozen
    wr(12'h320, 32'h1FD, PM, "R3");
    strobe(ALL_EVT, 4);
    rd(12'hB03, PM, 32'h7, "R3");

    // R12 views (cycle ran three more edges after 0x100 was written)
    rd(12'hC03, PM, 32'h7, "R12");
    rd(12'hC83, PM, 32'h0, "R12");
    rd(12'hC02, PM, 32'h5, "R12");
    rd(12'hC00, PM, 32'h103, "R12");
    rd(12'hC80, PM, 32'h14, "R12");

    // R9 supervisor gating
    refused(1'b0, 12'hC03, PS, "R9");
    wr(12'h306, 32'h8, PM, "R9");
    rd(12'hC03, PS, 32'h7, "R9");
    refused(1'b0, 12'hC04, PS, "R9");
    refused(1'b0, 12'hB03, PS, "R9");
    wr(12'h106, 32'h8, PS, "R10");
    rd(12'h106, PS, 32'h8, "R10");

    // R10 user gating
    rd(12'hC03, PU, 32'h7, "R10");
    wr(12'h106, 32'h0, PM, "R10");
    refused(1'b0, 12'hC03, PU, "R10");
    refused(1'b0, 12'h106, PU, "R10");

    // R11 refused writes and unmapped addresses
    refused(1'b1, 12'hC03, PM, "R11");
    rd(12'hB03, PM, 32'h7, "R11");
    refused(1'b0, 12'h7FF, PM, "R11");
    refused(1'b1, 12'hB01, PM, "R11");
    rd(12'h320, PM, 32'h1FD, "R11");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (q_data.size() != 0) begin
      n_bad++;
      $display("FAIL R13: %0d responses missing, expected 0", q_data.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13: watchdog expired, pending=%0d expected 0", q_data.size());
      summary();
      $finish;
    end
  end

endmodule